// File: doc/BRIEF.md
# PC Card Access Cycle Generator

This block turns one host request into one complete 16-bit PC Card / CompactFlash bus cycle. A request names the target space (common memory, attribute memory or I/O), the direction, the size (byte or word), the byte lane for byte accesses, an address and write data. From these fields the block works out which card enables go low, the level of the register-select line, and which strobe pair is used. Memory and attribute spaces use the output-enable and write-enable strobes. I/O space uses the I/O read and write strobes. Combinations the bus cannot carry are refused with an error response, and no card line moves.

An accepted cycle runs in three phases. The setup phase has the enables low and the strobe off. The access phase has the strobe on for a length programmed separately for each space. A card may stretch this phase through its active-low wait line when waiting is enabled for the bank. The hold phase has the strobe off and the enables still low. Read data is captured on the last strobe cycle, and a single-cycle response then reports the result.

Requests use a valid/ready handshake. `req_ready` is high only while no cycle is in progress, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the host must hold the request. The response is a one-cycle `rsp_valid` pulse and cannot be back-pressured. The host must keep the configuration inputs stable while a cycle is running.

Top module: `pccard_cycle_gen`

## Requirements
- R1: After reset, and whenever no cycle is running, every card control output (both enables, register-select, all four strobes) is high, `card_doe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A common-memory request (`req_space`=0) with `req_word`=0 and `req_hi`=0 drives the primary enable low, the secondary enable high and register-select high. It strobes output-enable for a read or write-enable for a write, with the data on bits 7..0.
- R3: A word request (`req_word`=1) in common memory or I/O (`req_space`=2) drives both enables low and moves data on bits 15..0. It is accepted only when address bit 0 is 0.
- R4: An attribute request (`req_space`=1) drives register-select low, the primary enable low and the secondary enable high, and uses output-enable or write-enable. It is always a byte on bits 7..0, whatever `req_word` and `req_hi` say.
- R5: An attribute request at an odd address still runs a full bus cycle, and its response has `rsp_inv`=1. All other completed cycles report `rsp_inv`=0.
- R6: An I/O byte request drives register-select low and the primary enable low, with the secondary enable high. It strobes I/O-read or I/O-write, keeps output-enable and write-enable high, and works at both even and odd addresses on bits 7..0.
- R7: The block refuses these requests: a byte on the high lane (`req_word`=0, `req_hi`=1) in common memory or I/O, a word at an odd address in common memory or I/O, and `req_space`=3. No enable goes low, and `rsp_valid` with `rsp_err`=1 follows on the cycle after acceptance.
- R8: The enables go low `cfg_setup`+1 cycles before the strobe and stay low for `cfg_hold`+1 cycles after it.
- R9: Without a wait extension, the strobe is active for exactly the programmed length of the space: `cfg_mem_len`, `cfg_att_len` or `cfg_io_len`. Each length must exceed MINW (2).
- R10: With `cfg_wait_en`=1, the wait line is sampled at the end of each strobe cycle from cycle MINW on. The strobe ends at the end of the first cycle, no earlier than the programmed length, in which the wait line is high. With `cfg_wait_en`=0, the wait line is ignored.
- R11: At most one of the four strobes is low in any cycle, and a strobe is low only while an enable is low.
- R12: `rsp_valid` rises on the cycle after the last hold cycle. A read returns the data captured on the last strobe cycle, zero-extended for a byte. A write returns zero.
- R13: During a write cycle, `card_doe` is high from setup through hold. `card_dout` carries the whole word for a word access, or the low byte with bits 15..8 at zero for a byte access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_space | input | 2 | 0 common memory, 1 attribute, 2 I/O, 3 reserved |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word access, 0 byte access |
| req_hi | input | 1 | Byte access on the high lane |
| req_addr | input | AW | Card address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request refused, no cycle run |
| rsp_inv | output | 1 | Cycle ran but was invalid (odd attribute address) |
| rsp_rdata | output | 16 | Read data |
| cfg_setup | input | LW | Setup cycles minus one |
| cfg_hold | input | LW | Hold cycles minus one |
| cfg_mem_len | input | LW | Common-memory strobe length |
| cfg_att_len | input | LW | Attribute strobe length |
| cfg_io_len | input | LW | I/O strobe length |
| cfg_wait_en | input | 1 | Allow the card's wait line to stretch the strobe |
| card_a | output | AW | Card address lines |
| card_ce1_n | output | 1 | Primary card enable, active low |
| card_ce2_n | output | 1 | Secondary card enable, active low |
| card_reg_n | output | 1 | Register-select, active low |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_wait_n | input | 1 | Card wait request, active low |
| card_dout | output | 16 | Data driven to the card |
| card_doe | output | 1 | Data output enable |
| card_din | input | 16 | Data from the card |

## Verification
A refused request must produce its error response on the cycle after the accepting edge. An accepted one must produce its response (setup+1) + strobe + (hold+1) + 1 cycles after that edge, where the strobe length is the programmed length or the wait-stretched length. The driver notes the cycle count at the accepting edge and pushes the expected lines, phase lengths and data into a queue. The monitor samples on falling edges and measures the setup, strobe and hold cycles directly from the enables and strobes. It also drives the card's wait line low for a chosen number of strobe cycles. When `rsp_valid` appears, the monitor pops the queue and compares every field and the exact latency.

// File: rtl/pccard_pkg.sv
package pccard_pkg;
  typedef enum logic [1:0] {
    SP_MEM = 2'd0,
    SP_ATT = 2'd1,
    SP_IO  = 2'd2,
    SP_RSV = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACC   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef struct packed {
    logic ce1_n;
    logic ce2_n;
    logic reg_n;
    logic io;
    logic err;
    logic inv;
  } lines_t;
endpackage

// File: rtl/pccard_decode.sv
module pccard_decode
  import pccard_pkg::*;
(
  input  space_e space,
  input  logic   word,
  input  logic   hi,
  input  logic   a0,
  output lines_t lines
);
  always_comb begin
    lines = '{ce1_n: 1'b1, ce2_n: 1'b1, reg_n: 1'b1, io: 1'b0, err: 1'b0, inv: 1'b0};
    unique case (space)
      SP_MEM, SP_IO: begin
        lines.reg_n = (space == SP_MEM);
        lines.io    = (space == SP_IO);
        if (word) begin
          lines.ce1_n = 1'b0;
          lines.ce2_n = 1'b0;
          lines.err   = a0;
        end else if (hi) begin
          lines.err   = 1'b1;
        end else begin
          lines.ce1_n = 1'b0;
        end
      end
      SP_ATT: begin
        lines.ce1_n = 1'b0;
        lines.reg_n = 1'b0;
        lines.inv   = a0;
      end
      default: lines.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/pccard_phase.sv
module pccard_phase
  import pccard_pkg::*;
#(
  parameter int LW   = 4,
  parameter int MINW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] setup_len,
  input  logic [LW-1:0] acc_len,
  input  logic [LW-1:0] hold_len,
  input  logic          wait_en,
  input  logic          wait_n,
  output phase_e        phase,
  output logic          capture,
  output logic          done
);
  localparam int KW = LW + 1;

  logic [LW-1:0] cnt;
  logic [KW-1:0] k;
  logic          stretch;
  logic          acc_end;

  assign stretch = wait_en && (k >= KW'(MINW)) && !wait_n;
  assign acc_end = (phase == PH_ACC) && (k >= {1'b0, acc_len}) && !stretch;
  assign capture = acc_end;
  assign done    = (phase == PH_HOLD) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      k     <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_SETUP;
          cnt   <= setup_len;
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_ACC;
            k     <= KW'(1);
          end else begin
            cnt <= cnt - LW'(1);
          end
        end
        PH_ACC: begin
          if (acc_end) begin
            phase <= PH_HOLD;
            cnt   <= hold_len;
          end else if (k != '1) begin
            k <= k + KW'(1);
          end
        end
        PH_HOLD: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - LW'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pccard_cycle_gen.sv
module pccard_cycle_gen
  import pccard_pkg::*;
#(
  parameter int AW   = 11,
  parameter int LW   = 4,
  parameter int MINW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_space,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_hi,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic          rsp_inv,
  output logic [15:0]   rsp_rdata,
  input  logic [LW-1:0] cfg_setup,
  input  logic [LW-1:0] cfg_hold,
  input  logic [LW-1:0] cfg_mem_len,
  input  logic [LW-1:0] cfg_att_len,
  input  logic [LW-1:0] cfg_io_len,
  input  logic          cfg_wait_en,
  output logic [AW-1:0] card_a,
  output logic          card_ce1_n,
  output logic          card_ce2_n,
  output logic          card_reg_n,
  output logic          card_oe_n,
  output logic          card_we_n,
  output logic          card_iord_n,
  output logic          card_iowr_n,
  input  logic          card_wait_n,
  output logic [15:0]   card_dout,
  output logic          card_doe,
  input  logic [15:0]   card_din
);
  localparam int DW = 16;
  localparam int BW = DW / 2;

  phase_e        phase;
  logic          capture, done;
  lines_t        dec;
  logic          accept, start;
  logic          l_ce1_n, l_ce2_n, l_reg_n, l_io, l_inv, l_write, l_word;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wdata;
  logic [LW-1:0] acc_len;
  logic          active, strobe;

  pccard_decode u_dec (
    .space (space_e'(req_space)),
    .word  (req_word),
    .hi    (req_hi),
    .a0    (req_addr[0]),
    .lines (dec)
  );

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign start     = accept && !dec.err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_ce1_n <= 1'b1;
      l_ce2_n <= 1'b1;
      l_reg_n <= 1'b1;
      l_io    <= 1'b0;
      l_inv   <= 1'b0;
      l_write <= 1'b0;
      l_word  <= 1'b0;
      l_addr  <= '0;
      l_wdata <= '0;
    end else if (start) begin
      l_ce1_n <= dec.ce1_n;
      l_ce2_n <= dec.ce2_n;
      l_reg_n <= dec.reg_n;
      l_io    <= dec.io;
      l_inv   <= dec.inv;
      l_write <= req_write;
      l_word  <= !dec.ce2_n;
      l_addr  <= req_addr;
      l_wdata <= req_wdata;
    end
  end

  always_comb begin
    if (l_io)         acc_len = cfg_io_len;
    else if (l_reg_n) acc_len = cfg_mem_len;
    else              acc_len = cfg_att_len;
  end

  pccard_phase #(.LW(LW), .MINW(MINW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .setup_len (cfg_setup),
    .acc_len   (acc_len),
    .hold_len  (cfg_hold),
    .wait_en   (cfg_wait_en),
    .wait_n    (card_wait_n),
    .phase     (phase),
    .capture   (capture),
    .done      (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_inv   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (accept && dec.err) || done;
      if (accept) begin
        rsp_err   <= dec.err;
        rsp_inv   <= 1'b0;
        rsp_rdata <= '0;
      end else if (done) begin
        rsp_err <= 1'b0;
        rsp_inv <= l_inv;
      end
      if (capture && !l_write)
        rsp_rdata <= l_word ? card_din : {{(DW-BW){1'b0}}, card_din[BW-1:0]};
    end
  end

  assign active      = (phase != PH_IDLE);
  assign strobe      = (phase == PH_ACC);
  assign card_a      = l_addr;
  assign card_ce1_n  = active ? l_ce1_n : 1'b1;
  assign card_ce2_n  = active ? l_ce2_n : 1'b1;
  assign card_reg_n  = active ? l_reg_n : 1'b1;
  assign card_oe_n   = !(strobe && !l_io && !l_write);
  assign card_we_n   = !(strobe && !l_io &&  l_write);
  assign card_iord_n = !(strobe &&  l_io && !l_write);
  assign card_iowr_n = !(strobe &&  l_io &&  l_write);
  assign card_doe    = active && l_write;
  assign card_dout   = l_word ? l_wdata : {{(DW-BW){1'b0}}, l_wdata[BW-1:0]};
endmodule

// File: rtl/pccard_cycle_gen_chk.sv
module pccard_cycle_gen_chk #(
  parameter int MINW = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_err,
  input logic cfg_wait_en,
  input logic card_ce1_n,
  input logic card_ce2_n,
  input logic card_oe_n,
  input logic card_we_n,
  input logic card_iord_n,
  input logic card_iowr_n,
  input logic card_wait_n
);
  logic strb, en;
  assign strb = !(card_oe_n && card_we_n && card_iord_n && card_iowr_n);
  assign en   = !(card_ce1_n && card_ce2_n);

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!card_oe_n, !card_we_n, !card_iord_n, !card_iowr_n}) <= 1);

  assert_strobe_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> en);

  assert_setup_before_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb) |-> $past(en));

  assert_hold_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb) |-> en);

  assert_err_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> $past(req_valid && req_ready));

  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !req_ready);

  generate
    if (MINW <= 2) begin : g_wait
      assert_wait_stretch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wait_en && strb && $past(strb) && !card_wait_n) |=> strb);
    end
  endgenerate
endmodule

bind pccard_cycle_gen pccard_cycle_gen_chk #(.MINW(MINW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .cfg_wait_en (cfg_wait_en),
  .card_ce1_n  (card_ce1_n),
  .card_ce2_n  (card_ce2_n),
  .card_oe_n   (card_oe_n),
  .card_we_n   (card_we_n),
  .card_iord_n (card_iord_n),
  .card_iowr_n (card_iowr_n),
  .card_wait_n (card_wait_n)
);

// File: tb/tb_pccard_cycle_gen.sv
`timescale 1ns/1ps
module tb_pccard_cycle_gen;
  localparam int AW = 11;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_space = '0;
  logic          req_write = 1'b0, req_word = 1'b0, req_hi = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          rsp_valid, rsp_err, rsp_inv;
  logic [15:0]   rsp_rdata;
  logic [LW-1:0] cfg_setup = 4'd1, cfg_hold = 4'd2;
  logic [LW-1:0] cfg_mem_len = 4'd3, cfg_att_len = 4'd4, cfg_io_len = 4'd5;
  logic          cfg_wait_en = 1'b0;
  logic [AW-1:0] card_a;
  logic          card_ce1_n, card_ce2_n, card_reg_n;
  logic          card_oe_n, card_we_n, card_iord_n, card_iowr_n;
  logic          card_wait_n = 1'b1;
  logic [15:0]   card_dout;
  logic          card_doe;
  logic [15:0]   card_din = '0;

  always #2.5 clk = ~clk;

  pccard_cycle_gen #(.AW(AW), .LW(LW), .MINW(2)) dut (.*);

  typedef struct {
    bit          err, inv, ce1, ce2, rg, wr;
    int          strb, nstrb, nset, nhold, acc_cyc;
    logic [15:0] rdata, dout;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int cyc = 0, nrsp = 0, wlow = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // monitor: measures phases at falling edges, drives wait, pops scoreboard
  int  m_set = 0, m_str = 0, m_hold = 0, m_kind = -1;
  bit  m_en = 0, m_ce1 = 1, m_ce2 = 1, m_rg = 1, m_multi = 0, m_doe = 0;
  logic [15:0] m_dout = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit en = !(card_ce1_n && card_ce2_n);
      automatic int ns = int'(!card_oe_n) + int'(!card_we_n) + int'(!card_iord_n) + int'(!card_iowr_n);
      if (en) m_en = 1;
      if (ns > 1) m_multi = 1;
      if (ns > 0) begin
        m_str++;
        if (m_str == 1) begin
          m_ce1 = card_ce1_n; m_ce2 = card_ce2_n; m_rg = card_reg_n;
          m_kind = !card_oe_n ? 0 : !card_we_n ? 1 : !card_iord_n ? 2 : 3;
          m_dout = card_dout; m_doe = card_doe;
          if (!en) m_multi = 1;
        end
      end else if (en && m_str == 0) m_set++;
      else if (en) m_hold++;
      card_wait_n = !(ns > 0 && m_str <= wlow);
      if (rsp_valid) begin
        if (q.size() == 0) chk(0, "R12", "unexpected response", 1, 0);
        else begin
          automatic exp_t e = q.pop_front();
          chk(rsp_err == e.err, "R7", "rsp_err", rsp_err, e.err);
          if (e.err) begin
            chk(!m_en, "R7", "enable moved on refused request", m_en, 0);
            chk(cyc - e.acc_cyc == 1, "R7", "error latency", cyc - e.acc_cyc, 1);
          end else begin
            chk(m_ce1 == e.ce1, e.tag, "ce1_n", m_ce1, e.ce1);
            chk(m_ce2 == e.ce2, e.tag, "ce2_n", m_ce2, e.ce2);
            chk(m_rg == e.rg, e.tag, "reg_n", m_rg, e.rg);
            chk(m_kind == e.strb, e.tag, "strobe kind", m_kind, e.strb);
            chk(!m_multi, "R11", "strobe overlap or strobe without enable", m_multi, 0);
            chk(m_str == e.nstrb, "R9 R10", "strobe cycles", m_str, e.nstrb);
            chk(m_set == e.nset, "R8", "setup cycles", m_set, e.nset);
            chk(m_hold == e.nhold, "R8", "hold cycles", m_hold, e.nhold);
            chk(rsp_inv == e.inv, "R5", "rsp_inv", rsp_inv, e.inv);
            chk(rsp_rdata == e.rdata, "R12", "rsp_rdata", rsp_rdata, e.rdata);
            chk(cyc - e.acc_cyc == e.nset + e.nstrb + e.nhold + 1, "R12", "response latency",
                cyc - e.acc_cyc, e.nset + e.nstrb + e.nhold + 1);
            if (e.wr) begin
              chk(m_doe, "R13", "card_doe", m_doe, 1);
              chk(m_dout == e.dout, "R13", "card_dout", m_dout, e.dout);
            end
          end
        end
        m_set = 0; m_str = 0; m_hold = 0; m_kind = -1;
        m_en = 0; m_multi = 0; m_ce1 = 1; m_ce2 = 1; m_rg = 1; m_doe = 0;
        nrsp++;
      end
    end
  end

  task automatic do_req(input int sp, input bit wr, input bit word, input bit hi,
                        input logic [AW-1:0] addr, input logic [15:0] wd, input logic [15:0] pat,
                        input int wl, input string tag);
    exp_t e;
    int   len, start_n;
    bit   wide;
    wide    = (sp != 1) && word;
    e.err   = (sp == 3) || (sp != 1 && !word && hi) || (sp != 1 && word && addr[0]);
    e.inv   = !e.err && sp == 1 && addr[0];
    e.ce1   = 0;
    e.ce2   = !wide;
    e.rg    = (sp == 0);
    e.wr    = wr;
    e.strb  = (sp == 2) ? (wr ? 3 : 2) : (wr ? 1 : 0);
    len     = (sp == 0) ? int'(cfg_mem_len) : (sp == 1) ? int'(cfg_att_len) : int'(cfg_io_len);
    e.nstrb = (cfg_wait_en && wl > 0 && wl + 1 > len) ? wl + 1 : len;
    e.nset  = int'(cfg_setup) + 1;
    e.nhold = int'(cfg_hold) + 1;
    e.rdata = (e.err || wr) ? 16'h0 : wide ? pat : {8'h00, pat[7:0]};
    e.dout  = wide ? wd : {8'h00, wd[7:0]};
    e.tag   = tag;
    card_din = pat;
    wlow     = wl;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_space = 2'(sp); req_write = wr; req_word = word; req_hi = hi;
    req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    e.acc_cyc = cyc;
    q.push_back(e);
    start_n = nrsp;
    @(negedge clk);
    req_valid = 1'b0;
    while (nrsp == start_n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nrsp, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(card_ce1_n && card_ce2_n && card_reg_n, "R1", "enables idle", {card_ce1_n, card_ce2_n, card_reg_n}, 7);
    chk(card_oe_n && card_we_n && card_iord_n && card_iowr_n, "R1", "strobes idle",
        {card_oe_n, card_we_n, card_iord_n, card_iowr_n}, 15);
    chk(req_ready && !rsp_valid && !card_doe, "R1", "ready/rsp/doe", {req_ready, rsp_valid, card_doe}, 4);

    do_req(0, 0, 0, 0, 11'h010, 16'h0000, 16'hBEEF, 0, "R2");   // common byte read
    do_req(0, 1, 0, 0, 11'h013, 16'h1234, 16'h0000, 0, "R2");   // common byte write
    do_req(0, 1, 1, 0, 11'h020, 16'hCAFE, 16'h0000, 0, "R3");   // common word write
    do_req(2, 0, 1, 0, 11'h040, 16'h0000, 16'h5A3C, 0, "R3");   // io word read
    do_req(0, 0, 1, 0, 11'h021, 16'h0000, 16'h0000, 0, "R3");   // odd word refused
    do_req(2, 1, 1, 0, 11'h041, 16'h0000, 16'h0000, 0, "R3");   // odd io word refused
    do_req(0, 0, 0, 1, 11'h030, 16'h0000, 16'h0000, 0, "R7");   // high lane mem
    do_req(2, 1, 0, 1, 11'h031, 16'h0000, 16'h0000, 0, "R7");   // high lane io
    do_req(3, 0, 0, 0, 11'h000, 16'h0000, 16'h0000, 0, "R7");   // reserved space
    do_req(1, 0, 0, 0, 11'h200, 16'h0000, 16'h7E81, 0, "R4");   // attribute even read
    do_req(1, 1, 1, 1, 11'h202, 16'hA55A, 16'h0000, 0, "R4");   // attribute ignores size fields
    do_req(1, 0, 0, 0, 11'h203, 16'h0000, 16'h00C4, 0, "R5");   // attribute odd: runs, invalid
    do_req(2, 0, 0, 0, 11'h051, 16'h0000, 16'hFF96, 0, "R6");   // io odd byte read
    do_req(2, 1, 0, 0, 11'h050, 16'h0077, 16'h0000, 0, "R6");   // io even byte write

    // R10 wait extension enabled
    cfg_wait_en = 1'b1;
    do_req(0, 0, 1, 0, 11'h060, 16'h0000, 16'h1357, 6, "R10");  // stretched to 7
    do_req(2, 0, 0, 0, 11'h061, 16'h0000, 16'h2468, 2, "R10");  // short wait, no stretch
    // R10 wait ignored when disabled
    cfg_wait_en = 1'b0;
    do_req(0, 0, 1, 0, 11'h062, 16'h0000, 16'h9ABC, 6, "R10");

    // R8 minimum setup and hold, longer access
    cfg_setup = 4'd0; cfg_hold = 4'd0; cfg_mem_len = 4'd6;
    do_req(0, 1, 0, 0, 11'h070, 16'h00E1, 16'h0000, 0, "R8");
    cfg_setup = 4'd3; cfg_hold = 4'd4;
    do_req(1, 1, 0, 0, 11'h072, 16'h0042, 16'h0000, 0, "R8");

    @(negedge clk);
    chk(q.size() == 0, "R12", "pending responses", q.size(), 0);
    chk(req_ready && card_ce1_n && card_ce2_n, "R1", "idle after traffic",
        {req_ready, card_ce1_n, card_ce2_n}, 7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule